// File: doc/BRIEF.md
# Clock-Loss Limp-Home and Stop-Recovery Controller

This block watches the external clock through a clock-monitor status input. If the external clock goes missing, it drops the system into limp-home operation on the internal clock. It does not watch the monitor all the time. A free-running prescaler sets a fixed check point once per period, and the monitor is read only at that point. When a check finds the clock missing, the controller saves the live clock-select state in a shadow copy. It then forces both selects to the internal source. A later check that finds the clock present restores the saved selects and raises an interrupt flag.

The same controller handles the low-power stop mode. A stop request gates the clocks. If pseudo-stop is enabled, the oscillator keeps running during the stop. Any of five wake-up sources ends the stop:

- an interrupt line
- a non-maskable interrupt line
- a key wake-up on port A
- a key wake-up on port B
- a CAN wake-up

When the delay bit is clear, the stop ends at once and the limp flag is not raised. When the delay bit is set, the part resumes in limp-home and waits for the next successful check.

Software writes to the selects go to the live selects in normal operation. While limp-home is active, they go to the shadow copy instead. Software can therefore clear the saved PLL select during limp-home, so the PLL stays unused after the clock returns.

Top module: `clkrec_limp_ctl`

## Requirements
- R1: After synchronous reset, the following outputs are 0: `limp_flag`, `limp_irq_flag`, `irq`, `pll_sel`, `mcs_sel`, `pll_en` and `stop_active`. `osc_en` is 1.
- R2: The monitor is read only at one edge per prescaler period of 2^CNT_W cycles. That edge is the one where the prescaler value is 2^(CNT_W-1), counted from 0 after reset. A loss of clock that begins and ends between two such edges has no effect.
- R3: Outside stop and outside limp-home, a check that sees `mon_ok`=0 sets `limp_flag`. On the same edge, the live selects are copied to the shadow and `pll_sel`/`mcs_sel` are forced to 0, which selects the internal clock. While limp-home is active, `pll_sel`, `mcs_sel` and `pll_en` are all 0.
- R4: In limp-home, a check that sees `mon_ok`=1 has three effects on the same edge: `limp_flag` clears, `limp_irq_flag` sets, and the selects take the shadow values.
- R5: `pll_en` is 1 exactly when all of these hold: `auto_en`=1, `pll_sel`=1, no limp-home and no stop.
- R6: A `cfg_we` pulse in limp-home writes `cfg_pll_sel`/`cfg_mcs_sel` into the shadow, and the live selects stay unchanged. Outside limp-home, the pulse writes the live selects. After a shadow write, the restored values are the ones written.
- R7: A `flag_clr` pulse clears `limp_irq_flag`. `irq` is `limp_irq_flag` AND `irq_en`.
- R8: `stop_req` outside stop sets `stop_active` on the next edge. During stop, `osc_en` is 1 only if `pstop_en` was 1 at entry, and `pll_en` is 0.
- R9: A 1 on any bit of `wake_src` during stop clears `stop_active` on the next edge. The bits are: 0 interrupt, 1 non-maskable interrupt, 2 key port A, 3 key port B, 4 CAN. Wake bits outside stop have no effect.
- R10: A stop exit with `dly_en`=0 leaves `limp_flag` at 0. A stop exit with `dly_en`=1 enters limp-home with the selects saved, exactly as in R3, and a later check with `mon_ok`=1 restores them.
- R11: No monitor check takes effect while `stop_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_ok | input | 1 | Clock monitor: external clock present |
| stop_req | input | 1 | Stop request pulse |
| pstop_en | input | 1 | Pseudo-stop enable |
| dly_en | input | 1 | Stop-exit delay enable |
| auto_en | input | 1 | Automatic PLL mode |
| wake_src | input | NWAKE | Wake-up sources |
| cfg_we | input | 1 | Select write strobe |
| cfg_pll_sel | input | 1 | PLL select write data |
| cfg_mcs_sel | input | 1 | Module-clock select write data |
| irq_en | input | 1 | Limp-exit interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| limp_flag | output | 1 | Limp-home active |
| limp_irq_flag | output | 1 | Limp-home exit interrupt flag |
| irq | output | 1 | Interrupt request |
| pll_sel | output | 1 | Live PLL clock-source select |
| mcs_sel | output | 1 | Live module-clock select |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| stop_active | output | 1 | Stop or pseudo-stop in progress |

## Verification
The bench builds the block with CNT_W=4, so a monitor check falls every 16 cycles. This puts many limp-home entries and exits, stop cycles and in-between clock glitches within reach of a short run. NWAKE stays at 5, so every wake source is driven one by one. With the default CNT_W of 13, a single check would need 8192 cycles.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

    typedef struct packed {
        logic pll;
        logic mcs;
    } clksel_t;

    typedef struct packed {
        logic    limp;
        logic    flag;
        logic    stopped;
        logic    pseudo;
        clksel_t live;
        clksel_t shadow;
    } ctl_state_t;

endpackage

// File: rtl/clkrec_prescaler.sv
module clkrec_prescaler #(
    parameter int CNT_W = 13
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [CNT_W-1:0] CHECK_AT = CNT_W'(1) << (CNT_W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = rst ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == CHECK_AT);
endmodule

// File: rtl/clkrec_wake.sv
module clkrec_wake #(
    parameter int NWAKE = 5
) (
    input  logic [NWAKE-1:0] wake_src,
    input  logic             stopped,
    output logic             wake_hit
);
    logic [NWAKE:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NWAKE; i++) begin : g_or
        assign chain[i+1] = chain[i] | wake_src[i];
    end

    assign wake_hit = stopped & chain[NWAKE];
endmodule

// File: rtl/clkrec_limp_ctl.sv
module clkrec_limp_ctl
    import clkrec_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int NWAKE = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mon_ok,
    input  logic             stop_req,
    input  logic             pstop_en,
    input  logic             dly_en,
    input  logic             auto_en,
    input  logic [NWAKE-1:0] wake_src,
    input  logic             cfg_we,
    input  logic             cfg_pll_sel,
    input  logic             cfg_mcs_sel,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic             limp_flag,
    output logic             limp_irq_flag,
    output logic             irq,
    output logic             pll_sel,
    output logic             mcs_sel,
    output logic             pll_en,
    output logic             osc_en,
    output logic             stop_active
);
    ctl_state_t st_d, st_q;
    logic       tick;
    logic       wake_hit;
    logic       set_flag;

    clkrec_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    clkrec_wake #(.NWAKE(NWAKE)) u_wake (
        .wake_src (wake_src),
        .stopped  (st_q.stopped),
        .wake_hit (wake_hit)
    );

    always_comb begin
        st_d     = st_q;
        set_flag = 1'b0;

        // software select write: shadow while limping, live otherwise
        if (cfg_we) begin
            if (st_q.limp) begin
                st_d.shadow.pll = cfg_pll_sel;
                st_d.shadow.mcs = cfg_mcs_sel;
            end else begin
                st_d.live.pll = cfg_pll_sel;
                st_d.live.mcs = cfg_mcs_sel;
            end
        end

        if (st_q.stopped) begin
            if (wake_hit) begin
                st_d.stopped = 1'b0;
                st_d.pseudo  = 1'b0;
                if (dly_en && !st_q.limp) begin
                    st_d.limp   = 1'b1;
                    st_d.shadow = st_d.live;
                    st_d.live   = '0;
                end
            end
        end else begin
            if (tick) begin
                if (!st_q.limp && !mon_ok) begin
                    st_d.limp   = 1'b1;
                    st_d.shadow = st_d.live;
                    st_d.live   = '0;
                end else if (st_q.limp && mon_ok) begin
                    st_d.limp = 1'b0;
                    st_d.live = st_d.shadow;
                    set_flag  = 1'b1;
                end
            end
            if (stop_req) begin
                st_d.stopped = 1'b1;
                st_d.pseudo  = pstop_en;
            end
        end

        if (flag_clr) st_d.flag = 1'b0;
        if (set_flag) st_d.flag = 1'b1;

        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign limp_flag     = st_q.limp;
    assign limp_irq_flag = st_q.flag;
    assign irq           = st_q.flag & irq_en;
    assign pll_sel       = st_q.live.pll;
    assign mcs_sel       = st_q.live.mcs;
    assign pll_en        = !st_q.limp && !st_q.stopped && auto_en && st_q.live.pll;
    assign osc_en        = !st_q.stopped || st_q.pseudo;
    assign stop_active   = st_q.stopped;
endmodule

// File: rtl/clkrec_checker.sv
module clkrec_checker #(
    parameter int NWAKE = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             stop_req,
    input logic [NWAKE-1:0] wake_src,
    input logic             limp_flag,
    input logic             limp_irq_flag,
    input logic             irq,
    input logic             pll_sel,
    input logic             mcs_sel,
    input logic             pll_en,
    input logic             stop_active
);
    assert_check_edge_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(limp_flag) && !$past(stop_active)) |-> $past(tick));

    assert_exit_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(limp_flag) |-> $past(tick));

    assert_limp_internal_R3: assert property (@(posedge clk) disable iff (rst)
        limp_flag |-> (!pll_sel && !mcs_sel && !pll_en));

    assert_exit_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(limp_flag) |-> limp_irq_flag);

    assert_flag_from_limp_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(limp_irq_flag) |-> $past(limp_flag));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> limp_irq_flag);

    assert_stop_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_active) |-> $past(stop_req));

    assert_no_pll_in_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop_active |-> !pll_en);

    assert_wake_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_active && (|wake_src)) |=> !stop_active);

    assert_no_check_in_stop_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(stop_active) && stop_active) |-> $stable(limp_flag));
endmodule

bind clkrec_limp_ctl clkrec_checker #(.NWAKE(NWAKE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .stop_req      (stop_req),
    .wake_src      (wake_src),
    .limp_flag     (limp_flag),
    .limp_irq_flag (limp_irq_flag),
    .irq           (irq),
    .pll_sel       (pll_sel),
    .mcs_sel       (mcs_sel),
    .pll_en        (pll_en),
    .stop_active   (stop_active)
);

// File: tb/sim_clkrec_limp_ctl.sv
`timescale 1ns/1ps
module sim_clkrec_limp_ctl;
    localparam int CNT_W = 4;
    localparam int NWAKE = 5;
    localparam int HALF  = 1 << (CNT_W - 1);

    // {pll, mcs, auto, sw_clear_pll, exp_pll, exp_mcs, exp_pll_en}
    localparam logic [6:0] VEC [7] = '{
        7'b1110_111, 7'b1010_101, 7'b1100_110, 7'b0110_010,
        7'b1111_010, 7'b1011_000, 7'b0000_000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mon_ok = 1'b1, stop_req = 1'b0, pstop_en = 1'b0, dly_en = 1'b0, auto_en = 1'b0;
    logic [NWAKE-1:0] wake_src = '0;
    logic cfg_we = 1'b0, cfg_pll_sel = 1'b0, cfg_mcs_sel = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic limp_flag, limp_irq_flag, irq, pll_sel, mcs_sel, pll_en, osc_en, stop_active;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [CNT_W-1:0] ref_cnt;

    always #10 clk = ~clk;

    always @(posedge clk) ref_cnt <= rst ? '0 : ref_cnt + 1'b1;

    clkrec_limp_ctl #(.CNT_W(CNT_W), .NWAKE(NWAKE)) u0 (
        .clk(clk), .rst(rst), .mon_ok(mon_ok), .stop_req(stop_req), .pstop_en(pstop_en),
        .dly_en(dly_en), .auto_en(auto_en), .wake_src(wake_src), .cfg_we(cfg_we),
        .cfg_pll_sel(cfg_pll_sel), .cfg_mcs_sel(cfg_mcs_sel), .irq_en(irq_en),
        .flag_clr(flag_clr), .limp_flag(limp_flag), .limp_irq_flag(limp_irq_flag),
        .irq(irq), .pll_sel(pll_sel), .mcs_sel(mcs_sel), .pll_en(pll_en),
        .osc_en(osc_en), .stop_active(stop_active)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mon_ok = 1'b1; stop_req = 1'b0; pstop_en = 1'b0; dly_en = 1'b0;
        auto_en = 1'b0; wake_src = '0; cfg_we = 1'b0; irq_en = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // returns at the negedge just after a monitor-check edge
    task automatic wait_check();
        @(negedge clk);
        while (ref_cnt != CNT_W'(HALF + 1)) @(negedge clk);
    endtask

    task automatic write_sel(input logic p, input logic m);
        cfg_pll_sel = p; cfg_mcs_sel = m; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_stop(input logic ps);
        pstop_en = ps; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", {limp_flag, limp_irq_flag, irq, pll_sel, mcs_sel, pll_en, stop_active, osc_en},
            8'b0000_0001);

        // vector table: save / restore through limp-home (R3, R4, R5, R6)
        foreach (VEC[i]) begin
            do_reset();
            auto_en = VEC[i][4];
            write_sel(VEC[i][6], VEC[i][5]);
            chk("R6 live write", {6'b0, pll_sel, mcs_sel}, {6'b0, VEC[i][6], VEC[i][5]});
            chk("R5 pll_en run", {7'b0, pll_en}, {7'b0, VEC[i][6] & VEC[i][4]});
            mon_ok = 1'b0;
            wait_check();
            chk("R3 limp entry", {5'b0, limp_flag, pll_sel, mcs_sel}, 8'b100);
            chk("R3 no pll in limp", {7'b0, pll_en}, 8'h0);
            if (VEC[i][3]) begin
                write_sel(1'b0, VEC[i][5]);
                chk("R6 live untouched", {6'b0, pll_sel, mcs_sel}, 8'h0);
            end
            mon_ok = 1'b1;
            wait_check();
            chk("R4 exit flags", {6'b0, limp_flag, limp_irq_flag}, 8'b01);
            chk("R4 restore", {6'b0, pll_sel, mcs_sel}, {6'b0, VEC[i][2], VEC[i][1]});
            chk("R5 pll_en after", {7'b0, pll_en}, {7'b0, VEC[i][0]});
        end

        // R2: glitch between checks ignored, then sampled only at the milestone
        do_reset();
        wait_check();
        mon_ok = 1'b0;
        repeat (4) @(negedge clk);
        mon_ok = 1'b1;
        wait_check();
        chk("R2 glitch ignored", {7'b0, limp_flag}, 8'h0);
        mon_ok = 1'b0;
        @(negedge clk);
        while (ref_cnt != CNT_W'(HALF)) @(negedge clk);
        chk("R2 not before milestone", {7'b0, limp_flag}, 8'h0);
        @(negedge clk);
        chk("R3 at milestone", {7'b0, limp_flag}, 8'h1);

        // R7 interrupt gating and write-one-to-clear
        mon_ok = 1'b1;
        wait_check();
        chk("R7 irq masked", {6'b0, limp_irq_flag, irq}, 8'b10);
        irq_en = 1'b1;
        #1;
        chk("R7 irq enabled", {7'b0, irq}, 8'h1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7 clear", {6'b0, limp_irq_flag, irq}, 8'b00);

        // R8 full stop, R11 no checks in stop, R9 wake, R10 fast exit
        do_reset();
        auto_en = 1'b1;
        write_sel(1'b1, 1'b1);
        pulse_stop(1'b0);
        chk("R8 stop", {5'b0, stop_active, osc_en, pll_en}, 8'b100);
        mon_ok = 1'b0;
        wait_check();
        chk("R11 no check in stop", {7'b0, limp_flag}, 8'h0);
        mon_ok = 1'b1;
        wake_src = 5'b00001;
        @(negedge clk);
        wake_src = '0;
        chk("R10 fast exit", {6'b0, stop_active, limp_flag}, 8'b00);
        chk("R5 pll back", {6'b0, pll_sel, pll_en}, 8'b11);

        // R9 each wake source, pseudo-stop keeps oscillator (R8)
        for (int b = 0; b < NWAKE; b++) begin
            pulse_stop(1'b1);
            chk("R8 pseudo osc", {6'b0, stop_active, osc_en}, 8'b11);
            wake_src = NWAKE'(1) << b;
            @(negedge clk);
            wake_src = '0;
            chk("R9 wake source", {7'b0, stop_active}, 8'h0);
        end

        // R9 wake outside stop ignored
        wake_src = '1;
        @(negedge clk);
        wake_src = '0;
        chk("R9 wake ignored", {6'b0, stop_active, limp_flag}, 8'b00);

        // R10 delayed exit enters limp-home, recovers at a check
        dly_en = 1'b1;
        pulse_stop(1'b0);
        mon_ok = 1'b0;
        wake_src = 5'b10000;
        @(negedge clk);
        wake_src = '0;
        chk("R10 delayed limp", {5'b0, stop_active, limp_flag, pll_sel}, 8'b010);
        mon_ok = 1'b1;
        wait_check();
        chk("R10 recovered", {5'b0, limp_flag, pll_sel, mcs_sel}, 8'b011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule